// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a parameterised general-purpose I/O port that sits on a simple single-cycle register bus. Each pin has three pieces of state: an output latch bit, an output-enable bit, and an input sample taken through a synchroniser. The block drives output values and output enables toward tristate pads. Reads return either the pin levels or the stored register state.

The style of output register is chosen when the block is built. It can be a plain data register, a set register paired with a clear register, or a set register alone. The direction register is also optional, and its polarity is a build choice: either a 1 marks a pin as an output, or a 1 marks it as an input. Two further build options change the bus view. One reverses the mapping of register bits to pins. The other swaps bytes on bus words, and it applies only at 16 and 32 bits.

The register map uses word offsets. Data is at 0, set at 1, clear at 2 and direction at 3. The bus has no handshake. Each access takes exactly one cycle and is qualified by `bus_sel`, so no back-pressure is possible: a write lands on the clock edge where it is presented.

Top module: `mmio_gpio_port`

## Requirements
- R1: While reset is held, and right after it, the output latch is 0, every `pad_oe` bit is 0 whatever the direction polarity, and `bus_rdata` is 0.
- R2: A read of offset 0 returns the level of each pin as it stood two rising edges before the read edge, because of a two-flop synchroniser.
- R3: In the data-only variant, a write to offset 0 loads the whole output latch, and `pad_out` equals the latch.
- R4: In the set-plus-clear variant, a write to offset 1 sets each latch bit whose written bit is 1. A write to offset 2 clears each latch bit whose written bit is 1. Written 0 bits change nothing, and writes to offset 0 leave the latch unchanged.
- R5: In the set-only variant, a write to offset 1 loads the entire latch, so written 0 bits drive those pins low. When the set register is readable, a read of offset 1 returns the latch, in the set-only variant and in the set-plus-clear variant.
- R6: With output polarity (DIR_MODE=1), a direction bit of 1 enables the pin's driver. With input polarity (DIR_MODE=2), a direction bit of 1 releases it. A read of offset 3 returns the stored direction word.
- R7: With no direction register (DIR_MODE=0), a pin drives only while its latch bit is 1: `pad_oe` equals the latch, and `pad_out` equals the latch.
- R8: With BIT_REV=1, pin n corresponds to register bit (REG_W-1-n) on both writes and reads.
- R9: With BYTE_SWAP=1 at 16 or 32 bits, register byte i travels in bus byte (REG_W/8-1-i). At 8 and 64 bits the option has no effect.
- R10: Reads of absent registers, and every read of the clear offset, return 0. Writes to absent registers leave the latch and the direction state unchanged.
- R11: With LATCH_READBACK=1, a read of offset 0 returns the latch value for pins whose driver is enabled, and the synchronised level for all other pins.
- R12: `bus_rdata` is registered. It updates on the edge that samples a read and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset: 0 data, 1 set, 2 clear, 3 direction |
| bus_wdata | input | REG_W | Write word |
| bus_rdata | output | REG_W | Read word, valid the cycle after a read |
| pad_in | input | REG_W | Pin levels from the pads |
| pad_out | output | REG_W | Per-pin drive value |
| pad_oe | output | REG_W | Per-pin driver enable |

## Verification
A write changes `pad_out` and `pad_oe` on the same rising edge that samples it. A read word appears on `bus_rdata` at that edge and then holds. The level presented on `pad_in` reaches a data read only two edges later. The bench model applies each bus operation on the rising edge, keeps a short queue of past pad values to supply the two-edge lag, and compares all three outputs at every falling edge. Because of that, each result is checked in the first cycle it is due and in every cycle after it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int OUTM_DATA    = 0;
  localparam int OUTM_SETCLR  = 1;
  localparam int OUTM_SETONLY = 2;

  localparam int DIRM_NONE = 0;
  localparam int DIRM_OUT  = 1;
  localparam int DIRM_IN   = 2;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_DIR  = 2'd3
  } gpio_reg_e;

  // Source lane for bit b. Reversal and byte swap commute, so the mapping is
  // its own inverse and serves both directions.
  function automatic int lane_src(int b, int w, bit rev, bit swap);
    int r;
    r = b;
    if (rev) r = w - 1 - r;
    if (swap) r = 8 * ((w / 8) - 1 - (r / 8)) + (r % 8);
    return r;
  endfunction

endpackage

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int W    = 32,
  parameter bit REV  = 1'b0,
  parameter bit SWAP = 1'b0
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);
  import gpio_port_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_lane
    localparam int SRC_IDX = lane_src(b, W, REV, SWAP);
    assign dst[b] = src[SRC_IDX];
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad,
  output logic [W-1:0] sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pad;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W        = 32,
  parameter int OUT_MODE = OUTM_SETCLR,
  parameter int DIR_MODE = DIRM_OUT,
  parameter bit SET_RD   = 1'b1,
  parameter bit LATCH_RB = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  gpio_reg_e addr,
  input  logic [W-1:0] wdata_pin,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] oe,
  output logic [W-1:0] rd_pin
);
  localparam bit HAS_SET = (OUT_MODE != OUTM_DATA);
  localparam bit HAS_DIR = (DIR_MODE != DIRM_NONE);
  localparam logic [W-1:0] DIR_RST = (DIR_MODE == DIRM_IN) ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] latch_d;
  logic [W-1:0] dir_q;
  logic [W-1:0] data_view;

  always_comb begin
    latch_d = latch_q;
    if (wr_en) begin
      case (addr)
        REG_DATA: if (OUT_MODE == OUTM_DATA) latch_d = wdata_pin;
        REG_SET: begin
          if (OUT_MODE == OUTM_SETCLR)       latch_d = latch_q | wdata_pin;
          else if (OUT_MODE == OUTM_SETONLY) latch_d = wdata_pin;
        end
        REG_CLR: if (OUT_MODE == OUTM_SETCLR) latch_d = latch_q & ~wdata_pin;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  if (HAS_DIR) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          dir_q <= DIR_RST;
      else if (wr_en && addr == REG_DIR)   dir_q <= wdata_pin;
    end
  end else begin : g_nodir
    assign dir_q = DIR_RST;
  end

  if (DIR_MODE == DIRM_OUT) begin : g_oe_out
    assign oe = dir_q;
  end else if (DIR_MODE == DIRM_IN) begin : g_oe_in
    assign oe = ~dir_q;
  end else begin : g_oe_none
    assign oe = latch_q;
  end

  assign data_view = LATCH_RB ? ((oe & latch_q) | (~oe & sync_in)) : sync_in;

  always_comb begin
    rd_pin = '0;
    case (addr)
      REG_DATA: rd_pin = data_view;
      REG_SET:  if (HAS_SET && SET_RD) rd_pin = latch_q;
      REG_DIR:  if (HAS_DIR) rd_pin = dir_q;
      default:  rd_pin = '0;
    endcase
  end

  AST_SETCLR_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_MODE == OUTM_SETCLR && wr_en && addr == REG_SET) |=> ((latch_q & $past(wdata_pin)) == $past(wdata_pin))); // R4
  AST_SETCLR_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_MODE == OUTM_SETCLR && wr_en && addr == REG_CLR) |=> ((latch_q & $past(wdata_pin)) == '0)); // R4
  AST_SETONLY_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_MODE == OUTM_SETONLY && wr_en && addr == REG_SET) |=> (latch_q == $past(wdata_pin))); // R5
  AST_DATA_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_MODE == OUTM_DATA && wr_en && addr == REG_DATA) |=> (latch_q == $past(wdata_pin))); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(latch_q) && $stable(dir_q))); // R10

endmodule

// File: rtl/mmio_gpio_port.sv
module mmio_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int REG_W          = 32,
  parameter int OUT_MODE       = OUTM_SETCLR,
  parameter int DIR_MODE       = DIRM_OUT,
  parameter bit BIT_REV        = 1'b0,
  parameter bit BYTE_SWAP      = 1'b0,
  parameter bit SET_READABLE   = 1'b1,
  parameter bit LATCH_READBACK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] pad_in,
  output logic [REG_W-1:0] pad_out,
  output logic [REG_W-1:0] pad_oe
);
  localparam bit SWAP_EN = BYTE_SWAP && (REG_W == 16 || REG_W == 32);

  logic             wr_en, rd_en;
  gpio_reg_e        addr_e;
  logic [REG_W-1:0] wdata_pin, sync_in, latch_q, rd_pin, rd_bus;

  assign wr_en  = bus_sel & bus_we;
  assign rd_en  = bus_sel & ~bus_we;
  assign addr_e = gpio_reg_e'(bus_addr);

  gpio_lane_map #(.W(REG_W), .REV(BIT_REV), .SWAP(SWAP_EN)) u_map_wr (
    .src(bus_wdata), .dst(wdata_pin)
  );

  gpio_in_sync #(.W(REG_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad(pad_in), .sync(sync_in)
  );

  gpio_port_regs #(
    .W(REG_W), .OUT_MODE(OUT_MODE), .DIR_MODE(DIR_MODE),
    .SET_RD(SET_READABLE), .LATCH_RB(LATCH_READBACK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr_e),
    .wdata_pin(wdata_pin), .sync_in(sync_in),
    .latch_q(latch_q), .oe(pad_oe), .rd_pin(rd_pin)
  );

  gpio_lane_map #(.W(REG_W), .REV(BIT_REV), .SWAP(SWAP_EN)) u_map_rd (
    .src(rd_pin), .dst(rd_bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_bus;
  end

  assign pad_out = latch_q;

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata)); // R12
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr_e == REG_CLR) |=> (bus_rdata == '0)); // R10
  AST_DIR_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (DIR_MODE != DIRM_NONE && wr_en && addr_e == REG_DIR) |=>
      (pad_oe == ((DIR_MODE == DIRM_OUT) ? $past(wdata_pin) : ~$past(wdata_pin)))); // R6

endmodule

// File: tb/mmio_gpio_port_tb_top.sv
module gpio_ref_chk #(
  parameter int W        = 16,
  parameter int OUT_MODE = 1,
  parameter int DIR_MODE = 1,
  parameter bit BIT_REV  = 1'b0,
  parameter bit BYTE_SWAP = 1'b0,
  parameter bit SET_RD   = 1'b1,
  parameter bit LATCH_RB = 1'b0
) (
  input logic clk, rst_n, sel, we,
  input logic [1:0] addr,
  input logic [W-1:0] wdata, pad_in, pad_out, pad_oe, rdata
);
  localparam bit SW = BYTE_SWAP && (W == 16 || W == 32);
  int checks = 0;
  int fails = 0;
  logic [W-1:0] m_latch = '0, m_dir = '0, exp_rd = '0;
  logic [W-1:0] hist [$];
  string rd_tag = "R1";
  bit seen = 0;

  function automatic logic [W-1:0] remap(logic [W-1:0] v);
    logic [W-1:0] o;
    for (int n = 0; n < W; n++) begin
      int r, bi, bb;
      r  = BIT_REV ? (W - 1 - n) : n;
      bi = r / 8;
      bb = SW ? ((W / 8 - 1 - bi) * 8 + r % 8) : r;
      o[n] = v[bb];
    end
    return o;
  endfunction

  function automatic logic [W-1:0] exp_oe();
    if (DIR_MODE == 1) return m_dir;
    if (DIR_MODE == 2) return ~m_dir;
    return m_latch;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s W=%0d act=%h exp=%h at %0t", tag, W, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    seen = 1;
    if (!rst_n) begin
      m_latch = '0;
      m_dir   = (DIR_MODE == 2) ? {W{1'b1}} : {W{1'b0}};
      exp_rd  = '0;
      rd_tag  = "R1";
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
    end else begin
      logic [W-1:0] wp, sy, v, oe;
      hist.push_back(pad_in);
      if (hist.size() > 3) void'(hist.pop_front());
      sy = hist[hist.size()-3];
      wp = remap(wdata);
      oe = exp_oe();
      if (sel && !we) begin
        v = '0;
        case (addr)
          2'd0: begin
            for (int n = 0; n < W; n++) v[n] = (LATCH_RB && oe[n]) ? m_latch[n] : sy[n];
            rd_tag = LATCH_RB ? "R11" : "R2";
          end
          2'd1: begin
            if (OUT_MODE != 0 && SET_RD) begin v = m_latch; rd_tag = "R5"; end
            else rd_tag = "R10";
          end
          2'd2: rd_tag = "R10";
          default: begin
            if (DIR_MODE != 0) begin v = m_dir; rd_tag = "R6"; end
            else rd_tag = "R10";
          end
        endcase
        exp_rd = remap(v);
      end
      if (sel && we) begin
        case (addr)
          2'd0: if (OUT_MODE == 0) m_latch = wp;
          2'd1: begin
            if (OUT_MODE == 1) m_latch = m_latch | wp;
            else if (OUT_MODE == 2) m_latch = wp;
          end
          2'd2: if (OUT_MODE == 1) m_latch = m_latch & ~wp;
          default: if (DIR_MODE != 0) m_dir = wp;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (seen) begin
      if (!rst_n) begin
        chk(pad_oe == '0, "R1 oe", 64'(pad_oe), 64'(0));
        chk(pad_out == '0, "R1 out", 64'(pad_out), 64'(0));
        chk(rdata == '0, "R1 rdata", 64'(rdata), 64'(0));
      end else begin
        chk(pad_out == m_latch, (OUT_MODE == 0) ? "R3 out" : (OUT_MODE == 1) ? "R4 out" : "R5 out",
            64'(pad_out), 64'(m_latch));
        chk(pad_oe == exp_oe(), (DIR_MODE == 0) ? "R7 oe" : "R6 oe", 64'(pad_oe), 64'(exp_oe()));
        chk(rdata == exp_rd, {rd_tag, " rdata (R12 hold)"}, 64'(rdata), 64'(exp_rd));
      end
    end
  end
endmodule

module mmio_gpio_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic sel = 0, we = 0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pad_a = '0, out_a, oe_a, rd_a;
  logic [7:0]  pad_b = '0, out_b, oe_b, rd_b;
  logic [31:0] pad_c = '0, out_c, oe_c, rd_c;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // A: 16-bit set+clear, output polarity, byte swap, latch readback
  mmio_gpio_port #(.REG_W(16), .OUT_MODE(1), .DIR_MODE(1), .BIT_REV(1'b0), .BYTE_SWAP(1'b1),
                   .SET_READABLE(1'b1), .LATCH_READBACK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata[15:0]),
    .bus_rdata(rd_a), .pad_in(pad_a), .pad_out(out_a), .pad_oe(oe_a));
  // B: 8-bit data-only, no direction register, byte swap requested (no effect)
  mmio_gpio_port #(.REG_W(8), .OUT_MODE(0), .DIR_MODE(0), .BIT_REV(1'b0), .BYTE_SWAP(1'b1),
                   .SET_READABLE(1'b1), .LATCH_READBACK(1'b0)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata[7:0]),
    .bus_rdata(rd_b), .pad_in(pad_b), .pad_out(out_b), .pad_oe(oe_b));
  // C: 32-bit set-only, input polarity, reversed bits
  mmio_gpio_port #(.REG_W(32), .OUT_MODE(2), .DIR_MODE(2), .BIT_REV(1'b1), .BYTE_SWAP(1'b0),
                   .SET_READABLE(1'b1), .LATCH_READBACK(1'b0)) dut_c_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rd_c), .pad_in(pad_c), .pad_out(out_c), .pad_oe(oe_c));

  gpio_ref_chk #(16, 1, 1, 1'b0, 1'b1, 1'b1, 1'b1) ref_a (clk, rst_n, sel, we, addr, wdata[15:0], pad_a, out_a, oe_a, rd_a);
  gpio_ref_chk #(8, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0) ref_b (clk, rst_n, sel, we, addr, wdata[7:0], pad_b, out_b, oe_b, rd_b);
  gpio_ref_chk #(32, 2, 2, 1'b1, 1'b0, 1'b1, 1'b0) ref_c (clk, rst_n, sel, we, addr, wdata, pad_c, out_c, oe_c, rd_c);

  task automatic dchk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_op(bit w, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d",
             checks + ref_a.checks + ref_b.checks + ref_c.checks,
             fails + ref_a.fails + ref_b.fails + ref_c.fails);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    dchk(oe_c == 32'h0 && out_c == 32'h0, "R1 reset C", {oe_c, out_c}, 64'h0);
    rst_n = 1;

    bus_op(1, 2'd1, 32'h0000_0001);                   // set
    dchk(out_a == 16'h0100, "R9 A swapped set", out_a, 16'h0100);
    dchk(out_b == 8'h00, "R10 B absent set", out_b, 8'h00);
    dchk(out_c == 32'h8000_0000, "R8 C reversed", out_c, 32'h8000_0000);

    bus_op(1, 2'd0, 32'h0000_0001);                   // data
    dchk(out_a == 16'h0100, "R4 A data ignored", out_a, 16'h0100);
    dchk(out_b == 8'h01, "R3 R9 B data load, no swap", out_b, 8'h01);

    bus_op(1, 2'd3, 32'h0000_FFFF);                   // direction
    dchk(oe_a == 16'hFFFF, "R6 A out-polarity", oe_a, 16'hFFFF);
    dchk(oe_c == 32'h0000_FFFF, "R6 C in-polarity", oe_c, 32'h0000_FFFF);
    dchk(oe_b == 8'h01, "R7 B oe follows latch", oe_b, 8'h01);

    bus_op(1, 2'd2, 32'h0000_0001);                   // clear
    dchk(out_a == 16'h0000, "R4 A clear", out_a, 16'h0000);
    dchk(out_c == 32'h8000_0000, "R10 C absent clear", out_c, 32'h8000_0000);

    bus_op(1, 2'd1, 32'h0000_0002);                   // set again
    dchk(out_c == 32'h4000_0000, "R5 C set-only full load", out_c, 32'h4000_0000);
    dchk(out_a == 16'h0200, "R4 A set", out_a, 16'h0200);

    bus_op(0, 2'd1, 32'h0);                           // read set
    dchk(rd_a == 16'h0002, "R5 A set readback", rd_a, 16'h0002);
    dchk(rd_c == 32'h0000_0002, "R5 C set readback", rd_c, 32'h0000_0002);
    dchk(rd_b == 8'h00, "R10 B absent read", rd_b, 8'h00);

    @(negedge clk);
    pad_a = 16'hFFFF; pad_b = 8'h5A; pad_c = 32'hABCD_0000;
    repeat (3) @(negedge clk);
    bus_op(0, 2'd0, 32'h0);                           // read data
    dchk(rd_a == 16'h0002, "R11 A latch readback", rd_a, 16'h0002);
    dchk(rd_b == 8'h5A, "R2 B pin level", rd_b, 8'h5A);
    dchk(rd_c == 32'h0000_B3D5, "R2 R8 C pin level reversed", rd_c, 32'h0000_B3D5);
    bus_op(1, 2'd0, 32'h0);
    dchk(rd_b == 8'h5A, "R12 B rdata holds", rd_b, 8'h5A);

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      sel   = ($urandom % 3) != 0;
      we    = $urandom % 2;
      addr  = 2'($urandom % 4);
      wdata = $urandom;
      pad_a = 16'($urandom);
      pad_b = 8'($urandom);
      pad_c = $urandom;
    end
    @(negedge clk);
    sel = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL R12 watchdog act=hung exp=completed");
      summary();
      $finish;
    end
  end
endmodule